// File: doc/BRIEF.md
# Register-Mapped GPIO Controller with Single-Pin Interrupt

This block gives a host processor control of 22 general-purpose pins through four 32-bit registers on a simple word-wide register port. Software reads the synchronised pin levels, sets output values and chooses for each pin whether it drives or listens. Each pin line has its own direction bit, output bit and input bit.

Interrupts are simple: one configuration register names a single pin by index and gives it a trigger mode. The single `irq` output follows that pin's level in the two level modes. In edge mode it holds a latched event flag. Software acknowledges an edge event by writing the configuration register again. A pin that drives an output never raises an interrupt. An index beyond the last pin selects nothing.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every register reads zero, `pin_oe` and `pin_out` are all zero and `irq` is low.
- R2: A write to byte offset 0x08 sets the output register. `pin_out[n]` equals bit n from the next clock edge on. The register reads back on 0x08 in the same cycle as `bus_rd`.
- R3: A write to byte offset 0x10 sets the direction register. Bit n = 1 drives `pin_oe[n]` high, which makes pin n an output. Bit n = 0 makes pin n an input.
- R4: A read of byte offset 0x00 returns the synchronised level of every pin, outputs included, with bit n holding pin n.
- R5: A change on `pin_in` becomes visible at offset 0x00 after exactly two rising clock edges, and not after one.
- R6: In the output and direction registers, bits 22 to 31 read as zero whatever was written. Offset 0x18 keeps only bits 7:0 and reads zero above them.
- R7: Offset 0x18 bits 5:0 select a pin and bits 7:6 select the mode. With mode 1 (low level), `irq` is high exactly while the selected input pin is synchronised low.
- R8: With mode 2 (high level), `irq` is high exactly while the selected input pin is synchronised high.
- R9: With mode 3 (edge), either transition of the selected input pin latches `irq` high. `irq` stays high through later pin changes until any write to offset 0x18 clears it.
- R10: If the selected pin has its direction bit set, `irq` stays low in every mode.
- R11: A selected index of 22 or above never raises `irq`.
- R12: With mode 0 (off), `irq` stays low whatever the pins do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte address; bits 4:3 pick the register, bits 2:0 must be zero |
| bus_wr | input | 1 | Write strobe, takes effect at the next rising edge |
| bus_rd | input | 1 | Read strobe; `bus_rdata` is valid in the same cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when `bus_rd` is low |
| pin_in | input | 22 | Asynchronous pin levels |
| pin_out | output | 22 | Output register value |
| pin_oe | output | 22 | Direction register value, 1 = drive |
| irq | output | 1 | Interrupt to the host |

## Verification
The bench samples the input register one edge after a pin change and then two edges after it. A design with a missing or extra synchroniser stage gives the wrong answer at one of those two points. In edge mode it raises a rising edge and then a falling edge without acknowledging in between. A design that clears the event flag when the pin returns, or that only sees rising edges, drops `irq` too early or never raises it. It also selects pins whose direction bit is set, and indices 22 and 30. A design that ignores direction or lets the index wrap raises an interrupt there. It writes all ones to every register to catch storage bits beyond pin 21 and beyond the configuration byte.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  typedef enum logic [1:0] {
    TRIG_OFF  = 2'd0,
    TRIG_LOW  = 2'd1,
    TRIG_HIGH = 2'd2,
    TRIG_EDGE = 2'd3
  } trig_e;

  // register slot = byte address bits [4:3]
  localparam logic [1:0] SLOT_IN  = 2'd0;
  localparam logic [1:0] SLOT_OUT = 2'd1;
  localparam logic [1:0] SLOT_DIR = 2'd2;
  localparam logic [1:0] SLOT_CFG = 2'd3;

  localparam int CFG_BITS = 8;
  localparam int SEL_W    = 6;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int WIDTH  = 22,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage[0] <= '0;
    else     stage[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[s] <= '0;
      else     stage[s] <= stage[s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 22,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr,
  input  logic                rd,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  input  logic [NUM_PINS-1:0] in_lvl,
  output logic [NUM_PINS-1:0] out_o,
  output logic [NUM_PINS-1:0] dir_o,
  output logic [CFG_BITS-1:0] cfg_o,
  output logic                cfg_wr_o
);
  localparam int PAD = DATA_W - NUM_PINS;
  localparam logic [DATA_W-1:0] PIN_MASK = {{PAD{1'b0}}, {NUM_PINS{1'b1}}};
  localparam logic [DATA_W-1:0] CFG_MASK = DATA_W'((1 << CFG_BITS) - 1);

  logic [DATA_W-1:0] out_q, dir_q, cfg_q;
  logic              aligned;
  logic [1:0]        slot;

  assign aligned = (addr[2:0] == 3'd0);
  assign slot    = addr[4:3];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
      dir_q <= '0;
      cfg_q <= '0;
    end else if (wr && aligned) begin
      case (slot)
        SLOT_OUT: out_q <= wdata & PIN_MASK;
        SLOT_DIR: dir_q <= wdata & PIN_MASK;
        SLOT_CFG: cfg_q <= wdata & CFG_MASK;
        default:  ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    if (rd && aligned) begin
      case (slot)
        SLOT_IN:  rdata = {{PAD{1'b0}}, in_lvl};
        SLOT_OUT: rdata = out_q;
        SLOT_DIR: rdata = dir_q;
        default:  rdata = cfg_q;
      endcase
    end
  end

  assign out_o    = out_q[NUM_PINS-1:0];
  assign dir_o    = dir_q[NUM_PINS-1:0];
  assign cfg_o    = cfg_q[CFG_BITS-1:0];
  assign cfg_wr_o = wr && aligned && (slot == SLOT_CFG);

  p_dir_update_r3: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == 5'h10) |=> (dir_o == $past(wdata[NUM_PINS-1:0])));
  p_out_update_r2: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == 5'h08) |=> (out_o == $past(wdata[NUM_PINS-1:0])));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 22
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] lvl,
  input  logic [NUM_PINS-1:0] dir,
  input  logic [SEL_W-1:0]    sel,
  input  trig_e               mode,
  input  logic                cfg_wr,
  output logic                irq
);
  logic [NUM_PINS-1:0] sel_hot, prev_q;
  logic                armed, lvl_sel, chg_sel, pend_q;

  // out-of-range index yields an all-zero one-hot vector
  always_comb begin
    for (int i = 0; i < NUM_PINS; i++) sel_hot[i] = (sel == SEL_W'(i));
  end

  assign armed   = |(sel_hot & ~dir);
  assign lvl_sel = |(sel_hot & lvl);
  assign chg_sel = |(sel_hot & (lvl ^ prev_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= lvl;
      if (cfg_wr)                                      pend_q <= 1'b0;
      else if (mode == TRIG_EDGE && armed && chg_sel) pend_q <= 1'b1;
    end
  end

  always_comb begin
    unique case (mode)
      TRIG_LOW:  irq = armed & ~lvl_sel;
      TRIG_HIGH: irq = armed &  lvl_sel;
      TRIG_EDGE: irq = armed &  pend_q;
      default:   irq = 1'b0;
    endcase
  end

  p_pend_clear_r9: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> !pend_q);
  p_edge_latch_r9: assert property (@(posedge clk) disable iff (rst)
    (mode == TRIG_EDGE && armed && chg_sel && !cfg_wr) |=> pend_q);
  p_off_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    (mode == TRIG_OFF) |-> !irq);
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS    = 22,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq
);
  logic [NUM_PINS-1:0] lvl_s;
  logic [CFG_BITS-1:0] cfg;
  logic                cfg_wr;
  logic [SEL_W-1:0]    sel;
  trig_e               mode;

  gpio_irq_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(lvl_s)
  );

  gpio_irq_regs #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wdata(bus_wdata), .rdata(bus_rdata), .in_lvl(lvl_s),
    .out_o(pin_out), .dir_o(pin_oe), .cfg_o(cfg), .cfg_wr_o(cfg_wr)
  );

  assign sel  = cfg[SEL_W-1:0];
  assign mode = trig_e'(cfg[CFG_BITS-1:SEL_W]);

  gpio_irq_detect #(.NUM_PINS(NUM_PINS)) u_detect (
    .clk(clk), .rst(rst), .lvl(lvl_s), .dir(pin_oe), .sel(sel),
    .mode(mode), .cfg_wr(cfg_wr), .irq(irq)
  );

  p_outpin_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (|(pin_oe & (NUM_PINS'(1) << sel))) |-> !irq);
  p_badsel_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (int'(sel) >= NUM_PINS) |-> !irq);
  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) |-> (pin_oe == '0 && pin_out == '0 && !irq));
endmodule

// File: tb/tb_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [31:0] bus_wdata, bus_rdata;
  logic [21:0] pin_in, pin_out, pin_oe;
  logic        irq;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_irq_ctrl dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(5'h00, v); chk("R1 in reg", v, 0);
    rd(5'h08, v); chk("R1 out reg", v, 0);
    rd(5'h10, v); chk("R1 dir reg", v, 0);
    rd(5'h18, v); chk("R1 cfg reg", v, 0);
    chk("R1 pin_oe", {10'd0, pin_oe}, 0);
    chk("R1 pin_out", {10'd0, pin_out}, 0);
    chk("R1 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_outreg();
    logic [31:0] v;
    wr(5'h08, 32'hFFFF_FFFF);
    chk("R2 pin_out all", {10'd0, pin_out}, 32'h003F_FFFF);
    rd(5'h08, v); chk("R6 out upper zero", v, 32'h003F_FFFF);
    wr(5'h08, 32'h0015_5AA5);
    chk("R2 pin_out pattern", {10'd0, pin_out}, 32'h0015_5AA5);
    rd(5'h08, v); chk("R2 out readback", v, 32'h0015_5AA5);
  endtask

  task automatic t_dir();
    logic [31:0] v;
    wr(5'h10, 32'hFFFF_FFFF);
    rd(5'h10, v); chk("R6 dir upper zero", v, 32'h003F_FFFF);
    wr(5'h10, 32'h0000_00F0);
    chk("R3 pin_oe", {10'd0, pin_oe}, 32'h0000_00F0);
    rd(5'h10, v); chk("R3 dir readback", v, 32'h0000_00F0);
  endtask

  task automatic t_input();
    logic [31:0] v;
    @(negedge clk);
    pin_in = 22'h2A_5A5A;
    @(negedge clk);
    rd(5'h00, v); chk("R5 one edge still old", v, 0);
    @(negedge clk);
    rd(5'h00, v); chk("R4 input incl outputs", v, 32'h002A_5A5A);
    pin_in = 22'h15_A5A5;
    wait_n(2);
    rd(5'h00, v); chk("R4 input second pattern", v, 32'h0015_A5A5);
  endtask

  task automatic t_cfg();
    logic [31:0] v;
    wr(5'h18, 32'hFFFF_FFFF);
    rd(5'h18, v); chk("R6 cfg byte only", v, 32'h0000_00FF);
    wr(5'h18, 32'h0000_0000);
    wr(5'h10, 32'h0);
    pin_in = '0;
    wait_n(3);
  endtask

  task automatic t_low();
    pin_in = 22'h00_0080;
    wr(5'h18, (1 << 6) | 7);
    wait_n(3);
    chk("R7 low mode pin high", {31'd0, irq}, 0);
    pin_in[7] = 1'b0;
    wait_n(3);
    chk("R7 low mode pin low", {31'd0, irq}, 1);
    pin_in[7] = 1'b1;
    wait_n(3);
    chk("R7 low mode released", {31'd0, irq}, 0);
  endtask

  task automatic t_high();
    pin_in = '0;
    wr(5'h18, (2 << 6) | 9);
    wait_n(3);
    chk("R8 high mode pin low", {31'd0, irq}, 0);
    pin_in[9] = 1'b1;
    wait_n(3);
    chk("R8 high mode pin high", {31'd0, irq}, 1);
    pin_in[9] = 1'b0;
    wait_n(3);
    chk("R8 high mode released", {31'd0, irq}, 0);
  endtask

  task automatic t_edge();
    pin_in = '0;
    wr(5'h18, (3 << 6) | 12);
    wait_n(3);
    chk("R9 edge idle", {31'd0, irq}, 0);
    pin_in[12] = 1'b1;
    wait_n(4);
    chk("R9 rising latched", {31'd0, irq}, 1);
    pin_in[12] = 1'b0;
    wait_n(4);
    chk("R9 held after return", {31'd0, irq}, 1);
    wr(5'h18, (3 << 6) | 12);
    chk("R9 cleared by cfg write", {31'd0, irq}, 0);
    wait_n(3);
    chk("R9 stays clear", {31'd0, irq}, 0);
    pin_in[12] = 1'b1;
    wait_n(4);
    wr(5'h18, (3 << 6) | 12);
    wait_n(2);
    pin_in[12] = 1'b0;
    wait_n(4);
    chk("R9 falling latched", {31'd0, irq}, 1);
    wr(5'h18, 0);
  endtask

  task automatic t_outpin();
    pin_in = '0;
    wr(5'h10, 32'h0000_0200);
    wr(5'h18, (2 << 6) | 9);
    pin_in[9] = 1'b1;
    wait_n(4);
    chk("R10 high mode on output pin", {31'd0, irq}, 0);
    wr(5'h18, (1 << 6) | 9);
    pin_in[9] = 1'b0;
    wait_n(4);
    chk("R10 low mode on output pin", {31'd0, irq}, 0);
    wr(5'h10, 32'h0);
    wait_n(1);
    chk("R10 input again fires", {31'd0, irq}, 1);
  endtask

  task automatic t_badsel();
    pin_in = '0;
    wr(5'h18, (1 << 6) | 22);
    wait_n(3);
    chk("R11 index 22 low mode", {31'd0, irq}, 0);
    wr(5'h18, (1 << 6) | 30);
    wait_n(3);
    chk("R11 index 30 low mode", {31'd0, irq}, 0);
  endtask

  task automatic t_off();
    pin_in = '0;
    wr(5'h18, 4);
    wait_n(3);
    chk("R12 off pin low", {31'd0, irq}, 0);
    pin_in[4] = 1'b1;
    wait_n(4);
    chk("R12 off after edge", {31'd0, irq}, 0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_wdata = '0; pin_in = '0;
    wait_n(4);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_outreg();
    t_dir();
    t_input();
    t_cfg();
    t_low();
    t_high();
    t_edge();
    t_outpin();
    t_badsel();
    t_off();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule